// File: doc/BRIEF.md
# MAC Soft Reset Sequencer

This block runs the ordered shutdown and restart that a MAC needs when software requests a soft reset. Software writes 1 to a single command bit. The sequencer then drops the transmit and receive enables. It waits until both datapaths report that they are between frames, asks the receive FIFO to flush, and waits for the FIFO to report that the flush is done. It then pulses a one-cycle clear to the statistics counters and raises the enables again. Only after all of that does it return the command bit to 0.

Software learns that the reset has finished by polling the command bit. The bit does not clear after a fixed delay. It clears only when every step of the sequence has completed. A busy output mirrors the same window for hardware consumers. The FIFO, the counters and the datapaths themselves sit outside this block.

Top module: `soft_reset_sequencer`

## Requirements
- R1: After hardware reset, cmdBit and busy are 0, txEnable and rxEnable are 1, and flushReq and cntClear are 0.
- R2: A write (cmdWrEn=1) with cmdWrData=1 while idle makes cmdBit and busy read 1 and drives txEnable and rxEnable to 0 from the next cycle.
- R3: flushReq stays 0 while txIdle and rxIdle are not both 1. It rises in the cycle after the first cycle in which both are 1. The enables are 0 whenever flushReq is 1.
- R4: Once raised, flushReq stays 1 until flushDone is seen at 1, and it falls in the following cycle.
- R5: cntClear is 1 for exactly one cycle, the cycle after flushDone is seen while flushReq is 1.
- R6: txEnable and rxEnable return to 1 in the cycle after cntClear. cmdBit and busy return to 0 one cycle later.
- R7: While a sequence runs, any write (data 1 or 0) has no effect on its outputs or on its timing. Writing 0 does not abort it.
- R8: flushDone at 1 outside the flush wait is ignored. This holds while idle and while waiting for the frame-idle inputs. A write of 0 while idle changes nothing.
- R9: busy always equals cmdBit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cmdWrEn | input | 1 | Write strobe for the command bit |
| cmdWrData | input | 1 | Value written to the command bit |
| cmdBit | output | 1 | Readback of the command bit |
| busy | output | 1 | High while a sequence is in progress |
| txEnable | output | 1 | Enable to transmit logic |
| rxEnable | output | 1 | Enable to receive logic |
| txIdle | input | 1 | Transmit logic is between frames |
| rxIdle | input | 1 | Receive logic is between frames |
| flushReq | output | 1 | Receive FIFO flush request |
| flushDone | input | 1 | Receive FIFO flush acknowledge |
| cntClear | output | 1 | One-cycle statistics counter clear |

## Verification
The bench runs the sequence with varied waits for idle and for flush completion, including zero waits. A design that skipped a wait would raise flushReq or cntClear a cycle early. Some runs hold only one of the two idle inputs high, which catches a design that starts the flush on either idle input instead of on both. Runs that write 1 and 0 during the sequence catch a design that restarts or aborts on those writes. Stray flushDone pulses, sent while idle and while draining, catch a design that advances on an acknowledge it never asked for.

// File: rtl/srst_pkg.sv
package srst_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_DRAIN  = 3'd1,
    SEQ_FLUSH  = 3'd2,
    SEQ_CLEAR  = 3'd3,
    SEQ_RESUME = 3'd4
  } seqState_t;

  typedef struct packed {
    logic start;
    logic dropEn;
    logic flushOn;
    logic flushOff;
    logic clrPulse;
    logic raiseEn;
    logic finish;
  } seqStrobes_t;
endpackage

// File: rtl/srst_ctrl.sv
module srst_ctrl
  import srst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startReq,
  input  logic        txIdle,
  input  logic        rxIdle,
  input  logic        flushDone,
  output seqStrobes_t strobes
);
  seqState_t state, nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      SEQ_IDLE: if (startReq) begin
        strobes.start  = 1'b1;
        strobes.dropEn = 1'b1;
        nextState      = SEQ_DRAIN;
      end
      SEQ_DRAIN: if (txIdle && rxIdle) begin
        strobes.flushOn = 1'b1;
        nextState       = SEQ_FLUSH;
      end
      SEQ_FLUSH: if (flushDone) begin
        strobes.flushOff = 1'b1;
        strobes.clrPulse = 1'b1;
        nextState        = SEQ_CLEAR;
      end
      SEQ_CLEAR: begin
        strobes.raiseEn = 1'b1;
        nextState       = SEQ_RESUME;
      end
      SEQ_RESUME: begin
        strobes.finish = 1'b1;
        nextState      = SEQ_IDLE;
      end
      default: nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= nextState;
  end

  AST_DRAIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_DRAIN && !(txIdle && rxIdle)) |=> state == SEQ_DRAIN); // R3
  AST_FLUSH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_FLUSH && !flushDone) |=> state == SEQ_FLUSH); // R4
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_IDLE && !startReq) |=> state == SEQ_IDLE); // R8
endmodule

// File: rtl/srst_dpath.sv
module srst_dpath
  import srst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  seqStrobes_t strobes,
  output logic        cmdBit,
  output logic        busy,
  output logic        txEnable,
  output logic        rxEnable,
  output logic        flushReq,
  output logic        cntClear
);
  logic bitReg, busyReg, enReg, flushReg, clrReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitReg   <= 1'b0;
      busyReg  <= 1'b0;
      enReg    <= 1'b1;
      flushReg <= 1'b0;
      clrReg   <= 1'b0;
    end else begin
      if (strobes.start)       begin bitReg <= 1'b1; busyReg <= 1'b1; end
      else if (strobes.finish) begin bitReg <= 1'b0; busyReg <= 1'b0; end
      if (strobes.dropEn)       enReg <= 1'b0;
      else if (strobes.raiseEn) enReg <= 1'b1;
      if (strobes.flushOn)       flushReg <= 1'b1;
      else if (strobes.flushOff) flushReg <= 1'b0;
      clrReg <= strobes.clrPulse;
    end
  end

  assign cmdBit   = bitReg;
  assign busy     = busyReg;
  assign txEnable = enReg;
  assign rxEnable = enReg;
  assign flushReq = flushReg;
  assign cntClear = clrReg;

  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cntClear |=> !cntClear); // R5
  AST_FLUSH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |-> (!txEnable && !rxEnable)); // R3
  AST_BUSY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy == cmdBit); // R9
  AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdBit && !strobes.finish) |=> cmdBit); // R7
endmodule

// File: rtl/soft_reset_sequencer.sv
module soft_reset_sequencer
  import srst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmdWrEn,
  input  logic cmdWrData,
  output logic cmdBit,
  output logic busy,
  output logic txEnable,
  output logic rxEnable,
  input  logic txIdle,
  input  logic rxIdle,
  output logic flushReq,
  input  logic flushDone,
  output logic cntClear
);
  seqStrobes_t strobes;

  srst_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startReq  (cmdWrEn && cmdWrData),
    .txIdle    (txIdle),
    .rxIdle    (rxIdle),
    .flushDone (flushDone),
    .strobes   (strobes)
  );

  srst_dpath u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .cmdBit   (cmdBit),
    .busy     (busy),
    .txEnable (txEnable),
    .rxEnable (rxEnable),
    .flushReq (flushReq),
    .cntClear (cntClear)
  );

  AST_FLUSH_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flushReq) |-> $past(txIdle && rxIdle)); // R3
  AST_CLEAR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cntClear) |-> $past(flushDone && flushReq)); // R5
endmodule

// File: tb/soft_reset_sequencer_test.sv
module soft_reset_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdWrEn = 1'b0, cmdWrData = 1'b0;
  logic txIdle = 1'b0, rxIdle = 1'b0, flushDone = 1'b0;
  logic cmdBit, busy, txEnable, rxEnable, flushReq, cntClear;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  soft_reset_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdBit(cmdBit), .busy(busy), .txEnable(txEnable), .rxEnable(rxEnable),
    .txIdle(txIdle), .rxIdle(rxIdle), .flushReq(flushReq),
    .flushDone(flushDone), .cntClear(cntClear)
  );

  // vector: idleWait[7:0], doneWait[7:0], partial, poke
  localparam int NVEC = 6;
  localparam logic [17:0] VECS [NVEC] = '{
    {8'd0, 8'd0, 1'b0, 1'b0},
    {8'd3, 8'd2, 1'b0, 1'b0},
    {8'd5, 8'd0, 1'b1, 1'b0},
    {8'd0, 8'd6, 1'b0, 1'b1},
    {8'd4, 8'd4, 1'b1, 1'b1},
    {8'd1, 8'd9, 1'b0, 1'b1}
  };

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkState(input string req, input logic eb, input logic ee,
                          input logic ef, input logic ec);
    chk(cmdBit === eb, req, "cmdBit", cmdBit, eb);
    chk(busy === eb, req, "busy(R9)", busy, eb);
    chk(txEnable === ee && rxEnable === ee, req, "enables",
        {txEnable, rxEnable}, {ee, ee});
    chk(flushReq === ef, req, "flushReq", flushReq, ef);
    chk(cntClear === ec, req, "cntClear", cntClear, ec);
  endtask

  task automatic runSeq(input int idleWait, input int doneWait,
                        input logic partial, input logic poke);
    @(negedge clk);
    txIdle = 1'b0; rxIdle = 1'b0;
    cmdWrEn = 1'b1; cmdWrData = 1'b1;
    @(negedge clk);
    cmdWrEn = 1'b0;
    chkState("R2", 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < idleWait; i++) begin
      txIdle = partial; rxIdle = 1'b0;
      cmdWrEn = poke; cmdWrData = i[0];   // R7 writes during run
      flushDone = poke;                   // R8 stray acknowledge while draining
      @(negedge clk);
      chkState("R3", 1'b1, 1'b0, 1'b0, 1'b0);
    end
    cmdWrEn = 1'b0; flushDone = 1'b0;
    txIdle = 1'b1; rxIdle = 1'b1;
    @(negedge clk);
    txIdle = 1'b0; rxIdle = 1'b0;
    chkState("R3", 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < doneWait; i++) begin
      cmdWrEn = poke; cmdWrData = i[0];
      @(negedge clk);
      chkState("R4", 1'b1, 1'b0, 1'b1, 1'b0);
    end
    cmdWrEn = poke; cmdWrData = 1'b0;
    flushDone = 1'b1;
    @(negedge clk);
    flushDone = 1'b0;
    chkState("R5", 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    cmdWrEn = 1'b0;
    chkState("R6", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chkState("R6", 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk(cmdBit === 1'b0, "R1", "cmdBit in reset", cmdBit, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chkState("R1", 1'b0, 1'b1, 1'b0, 1'b0);

    for (int v = 0; v < NVEC; v++)
      runSeq(int'(VECS[v][17:10]), int'(VECS[v][9:2]), VECS[v][1], VECS[v][0]);

    // R8: write 0 while idle changes nothing
    cmdWrEn = 1'b1; cmdWrData = 1'b0;
    @(negedge clk);
    cmdWrEn = 1'b0;
    @(negedge clk);
    chkState("R8", 1'b0, 1'b1, 1'b0, 1'b0);

    // R8: stray flushDone while idle is ignored
    flushDone = 1'b1; txIdle = 1'b1; rxIdle = 1'b1;
    repeat (2) @(negedge clk);
    flushDone = 1'b0;
    chkState("R8", 1'b0, 1'b1, 1'b0, 1'b0);

    // R7: writing 0 immediately after start does not abort
    @(negedge clk);
    txIdle = 1'b0; rxIdle = 1'b0;
    cmdWrEn = 1'b1; cmdWrData = 1'b1;
    @(negedge clk);
    cmdWrData = 1'b0;
    repeat (3) @(negedge clk);
    cmdWrEn = 1'b0;
    chkState("R7", 1'b1, 1'b0, 1'b0, 1'b0);
    txIdle = 1'b1; rxIdle = 1'b1;
    @(negedge clk);
    chkState("R7", 1'b1, 1'b0, 1'b1, 1'b0);
    flushDone = 1'b1;
    @(negedge clk);
    flushDone = 1'b0;
    chkState("R5", 1'b1, 1'b0, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chkState("R6", 1'b0, 1'b1, 1'b0, 1'b0);

    // back-to-back run right after completion
    runSeq(2, 1, 1'b1, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule